// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This datapath unit takes two signed 32-bit factors, forms their 64-bit two's-complement product and returns only the upper 32 bits of a 64-bit intermediate. The operation select chooses what that intermediate is. It can be the bare product. It can be the product plus an addend placed in the upper word. It can be the addend in the upper word minus the product. A rounding control can add half of the lower word's weight before the upper word is taken.

The unit is a fixed two-stage pipeline with no stall. A new operation may enter on every clock cycle, and each result leaves exactly two cycles after its operands. It produces no status flags. Overflow of the 64-bit intermediate wraps modulo 2^64.

Top module: `hiword_mac`

## Requirements
- R1: Both factors `opa_i` and `opb_i` are signed two's-complement, and the product is formed at 64 bits.
- R2: With `mode_i` = 2'b00 (plain multiply), `res_o` is bits [63:32] of the signed product P.
- R3: With `mode_i` = 2'b01 (accumulate), `res_o` is bits [63:32] of ({addend,32'b0} + P) mod 2^64.
- R4: With `mode_i` = 2'b10 (subtract), `res_o` is bits [63:32] of ({addend,32'b0} − P) mod 2^64.
- R5: With `mode_i` = 2'b11 (reserved), the unit gives the same result as plain multiply.
- R6: When `rnd_i` is 1, the constant 0x0000_0000_8000_0000 is added to the 64-bit intermediate last, before the upper word is taken. When `rnd_i` is 0, the result is truncated.
- R7: `vld_o` is `vld_i` delayed by exactly two cycles. `res_o` is the result for the operands presented with that earlier `vld_i`, and back-to-back operations are accepted.
- R8: Synchronous active-low reset `rst_n` clears both valid stages, so `vld_o` is 0 during reset and on the first cycle after it.
- R9: Corner cases: 0x80000000 × 0x80000000 gives 0x40000000 (plain, truncated). −1 × 1 gives 0xFFFFFFFF truncated and 0x00000000 rounded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Operands valid this cycle |
| opa_i | input | 32 | First signed factor |
| opb_i | input | 32 | Second signed factor |
| acc_i | input | 32 | Addend placed in the upper word |
| mode_i | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 as 00 |
| rnd_i | input | 1 | Round before taking the upper word |
| vld_o | output | 1 | Result valid |
| res_o | output | 32 | Upper 32 bits of the intermediate |

## Verification
Every result is due on the second rising edge after the edge that captured its operands. The bench drives the inputs on the falling edge. It then waits for two rising edges and samples `vld_o` and `res_o` on the falling edge that follows, so a pipeline that is one stage short or one stage long shows up as a mismatch. A second pass streams operands on consecutive cycles and compares each output against a queue of expected values that is exactly two entries deep. This checks both the throughput and the stage alignment.

// File: rtl/hiword_mac_pkg.sv
// Package: shared widths, mode encoding and stage structures for hiword_mac.
// Assumes: factors are signed, and the intermediate is twice the operand width.
package hiword_mac_pkg;
    localparam int unsigned W  = 32;
    localparam int unsigned W2 = 2 * W;

    typedef enum logic [1:0] {
        MODE_MUL  = 2'b00,
        MODE_ACC  = 2'b01,
        MODE_SUB  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    // Values carried from stage 1 to stage 2.
    typedef struct packed {
        logic [W2-1:0] prod;
        logic [W-1:0]  addend;
        mode_e         mode;
        logic          rnd;
    } s1_t;
endpackage

// File: rtl/hiword_mac_mult.sv
// Module: hiword_mac_mult - stage 1: registers the signed full-width product
// together with the side-band fields the next stage needs.
// Assumes: no stall; data registers are not reset, only the valid bit is.
module hiword_mac_mult
    import hiword_mac_pkg::*;
#(
    parameter int unsigned OW = W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  logic [OW-1:0]   opa_i,
    input  logic [OW-1:0]   opb_i,
    input  logic [OW-1:0]   acc_i,
    input  logic [1:0]      mode_i,
    input  logic            rnd_i,
    output logic            vld_o,
    output logic [2*OW-1:0] prod_o,
    output logic [OW-1:0]   acc_o,
    output logic [1:0]      mode_o,
    output logic            rnd_o
);
    localparam int unsigned PW = 2 * OW;

    logic signed [PW-1:0] prod_c;

    // Signed full-width product of the two factors.
    always_comb begin
        prod_c = PW'($signed(opa_i)) * PW'($signed(opb_i));
    end

    // Valid bit of stage 1, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Data registers of stage 1; they load on every cycle.
    always_ff @(posedge clk) begin
        prod_o <= prod_c;
        acc_o  <= acc_i;
        mode_o <= mode_i;
        rnd_o  <= rnd_i;
    end

    // R7: stage 1 valid follows its input by one cycle.
    a_r7_s1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);
    // R1: a zero factor gives a zero product one cycle later.
    a_r1_zero_factor: assert property (@(posedge clk) disable iff (!rst_n)
        (opa_i == '0 || opb_i == '0) |=> prod_o == '0);
endmodule

// File: rtl/hiword_mac_combine.sv
// Module: hiword_mac_combine - stage 2 logic: chooses the intermediate from
// the mode, adds the rounding constant, and extracts the upper word.
// Assumes: all arithmetic wraps modulo 2^(2*OW); reserved mode acts as multiply.
module hiword_mac_combine
    import hiword_mac_pkg::*;
#(
    parameter int unsigned OW = W
) (
    input  logic [2*OW-1:0] prod_i,
    input  logic [OW-1:0]   acc_i,
    input  logic [1:0]      mode_i,
    input  logic            rnd_i,
    output logic [OW-1:0]   hi_o
);
    localparam int unsigned PW = 2 * OW;
    localparam logic [PW-1:0] RND_K = PW'(1) << (OW - 1);

    logic [PW-1:0] acc_sh;
    logic [PW-1:0] base;
    logic [PW-1:0] total;

    // Addend moved into the upper word.
    always_comb begin
        acc_sh = {acc_i, {OW{1'b0}}};
    end

    // Intermediate chosen by the mode.
    always_comb begin
        unique case (mode_i)
            2'b01:   base = acc_sh + prod_i;
            2'b10:   base = acc_sh - prod_i;
            default: base = prod_i;
        endcase
    end

    // Rounding constant added last, then the upper word is taken.
    always_comb begin
        total = base + (rnd_i ? RND_K : '0);
        hi_o  = total[PW-1:OW];
    end
endmodule

// File: rtl/hiword_mac.sv
// Module: hiword_mac - top of the signed high-word multiply-accumulate unit.
// A two-stage pipeline: stage 1 registers the product, and stage 2 registers
// the combined and extracted result.
// Assumes: no stall; synchronous active-low reset clears the valid bits only.
module hiword_mac
    import hiword_mac_pkg::*;
#(
    parameter int unsigned OW = W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [OW-1:0] opa_i,
    input  logic [OW-1:0] opb_i,
    input  logic [OW-1:0] acc_i,
    input  logic [1:0]    mode_i,
    input  logic          rnd_i,
    output logic          vld_o,
    output logic [OW-1:0] res_o
);
    localparam int unsigned PW = 2 * OW;

    logic          s1_vld;
    logic [PW-1:0] s1_prod;
    logic [OW-1:0] s1_acc;
    logic [1:0]    s1_mode;
    logic          s1_rnd;
    logic [OW-1:0] hi_c;

    hiword_mac_mult #(.OW(OW)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_i),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .acc_i  (acc_i),
        .mode_i (mode_i),
        .rnd_i  (rnd_i),
        .vld_o  (s1_vld),
        .prod_o (s1_prod),
        .acc_o  (s1_acc),
        .mode_o (s1_mode),
        .rnd_o  (s1_rnd)
    );

    hiword_mac_combine #(.OW(OW)) u_comb (
        .prod_i (s1_prod),
        .acc_i  (s1_acc),
        .mode_i (s1_mode),
        .rnd_i  (s1_rnd),
        .hi_o   (hi_c)
    );

    // Valid bit of stage 2, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= s1_vld;
    end

    // Result register of stage 2.
    always_ff @(posedge clk) begin
        res_o <= hi_c;
    end

    // R7: output valid is the input valid two cycles earlier.
    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        s1_vld |=> vld_o);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> !vld_o);
    // R2: a plain product with a zero factor and no rounding gives zero.
    a_r2_zero_mul: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_mode == 2'b00 && !s1_rnd && s1_prod == '0) |=> res_o == '0);
    // R3: with a zero product, accumulate returns the addend.
    a_r3_acc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_mode == 2'b01 && !s1_rnd && s1_prod == '0) |=> res_o == $past(s1_acc));
    // R8: after a reset cycle the output is not valid.
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !vld_o);
endmodule

// File: tb/hiword_mac_tb.sv
module hiword_mac_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [31:0] opa_i = '0, opb_i = '0, acc_i = '0;
    logic [1:0]  mode_i = '0;
    logic        rnd_i = 1'b0;
    logic        vld_o;
    logic [31:0] res_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hiword_mac u_dut (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .opa_i(opa_i),
        .opb_i(opb_i), .acc_i(acc_i), .mode_i(mode_i), .rnd_i(rnd_i),
        .vld_o(vld_o), .res_o(res_o));

    // Reference model written from the requirements.
    function automatic logic [31:0] ref_f(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input logic [1:0] m,
                                          input logic r);
        logic [63:0] p, t;
        p = 64'($signed(a)) * 64'($signed(b));
        case (m)
            2'b01:   t = {c, 32'h0} + p;
            2'b10:   t = {c, 32'h0} - p;
            default: t = p;
        endcase
        if (r) t = t + 64'h8000_0000;
        return t[63:32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation, wait two edges, and sample on the falling edge.
    task automatic run1(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [1:0] m, input logic r,
                        input logic [31:0] exp);
        @(negedge clk);
        vld_i = 1'b1; opa_i = a; opb_i = b; acc_i = c; mode_i = m; rnd_i = r;
        @(negedge clk);
        vld_i = 1'b0;
        @(negedge clk);
        check({req, " valid"}, {31'b0, vld_o}, 32'd1);
        check(req, res_o, exp);
    endtask

    typedef struct packed {
        logic [31:0] a, b, c;
        logic [1:0]  m;
        logic        r;
        logic [31:0] e;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h8000_0000, 32'h8000_0000, 32'h0, 2'b00, 1'b0, 32'h4000_0000}, // R9
        '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 2'b00, 1'b0, 32'hFFFF_FFFF}, // R9
        '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 2'b00, 1'b1, 32'h0000_0000}, // R9 R6
        '{32'h0001_0000, 32'h0001_0000, 32'h0000_0005, 2'b01, 1'b0, 32'h0000_0006}, // R3
        '{32'h0001_0000, 32'h0001_0000, 32'h0000_0005, 2'b10, 1'b0, 32'h0000_0004}, // R4
        '{32'h0000_0001, 32'h0000_0001, 32'h0000_0005, 2'b10, 1'b0, 32'h0000_0004}, // R4 borrow
        '{32'h8000_0000, 32'h8000_0000, 32'h0, 2'b11, 1'b0, 32'h4000_0000}, // R5
        '{32'h0000_C000, 32'h0001_0000, 32'h0, 2'b00, 1'b1, 32'h0000_0001}  // R6 round up
    };

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] q_exp [$];
        logic [31:0] a, b, c, e;
        logic [1:0]  m;
        logic        r;
        repeat (3) @(negedge clk);
        check("R8 reset", {31'b0, vld_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", {31'b0, vld_o}, 32'd0);

        foreach (VECS[i])
            run1("R2/R9 table", VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].m,
                 VECS[i].r, VECS[i].e);

        run1("R2 product", 32'h0000_0003, 32'hFFFF_FFFE, 32'h0, 2'b00, 1'b0, 32'hFFFF_FFFF);
        run1("R1 signed", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 2'b00, 1'b0, 32'h3FFF_FFFF);

        // R7: back-to-back random stream in every mode, with and without rounding.
        for (int k = 0; k < 80000; k++) begin
            @(negedge clk);
            if (q_exp.size() == 2) begin
                e = q_exp.pop_front();
                check("R7 stream valid", {31'b0, vld_o}, 32'd1);
                check("R1-R6 stream", res_o, e);
            end
            a = $urandom; b = $urandom; c = $urandom;
            m = 2'(k % 4); r = 1'((k / 4) % 2);
            vld_i = 1'b1; opa_i = a; opb_i = b; acc_i = c; mode_i = m; rnd_i = r;
            q_exp.push_back(ref_f(a, b, c, m, r));
        end
        @(negedge clk);
        vld_i = 1'b0;
        e = q_exp.pop_front();
        check("R7 tail1", res_o, e);
        @(negedge clk);
        e = q_exp.pop_front();
        check("R7 tail2", res_o, e);
        @(negedge clk);
        check("R7 drained", {31'b0, vld_o}, 32'd0);

        // R8: a mid-run reset kills an operation in flight.
        @(negedge clk);
        vld_i = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        vld_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R8 flush", {31'b0, vld_o}, 32'd0);
        @(negedge clk);
        check("R8 flush2", {31'b0, vld_o}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule